// File: doc/BRIEF.md
# I/O Interrupt Redirection Unit

The block routes a set of external interrupt lines (24 by default) to vectored interrupt requests. Software reaches its registers through an index/data pair: a write to the selector offset picks an internal register, and accesses to the data-window offset read or write the register that is picked. The internal registers are an identification register, a read-only version register whose fields follow from the line count, an arbitration register that is always zero, and one two-word redirection entry for each line.

Each line is edge-detected. When a line rises and the mask bit in its entry is clear, a request is recorded as pending. Pending requests go out one at a time on a valid/ready stream that carries the 8-bit vector of the entry. If several are pending, the lowest line number is served first. Back-pressure rules: once `req_valid` is high, it stays high and `req_vector` stays constant until a cycle in which `req_ready` is also high. That cycle transfers the request, and the next pending request, if any, is presented in the cycle after it. `req_ready` can stay low for any length of time and no pending request is lost.

The register read port is combinational: `bus_rdata` is valid in the same cycle as `bus_rd` and is zero whenever `bus_rd` is low. Writes take effect at the clock edge.

Top module: `ioroute_top`

## Requirements
- R1: Offset 0x00 is the selector, and a write there stores `bus_wdata[7:0]`. Offset 0x10 is the data window. Reads at every other offset (0x00 included) return 0, and writes to any offset other than 0x00 and 0x10 change no register.
- R2: Internal register 0 holds the unit ID in bits 31:24, which reset to 0. A window write sets the ID from bits 31:24 of the data, and the other bits always read 0.
- R3: Internal register 1 is read-only and returns 0x11 | ((N-1) << 16), which is 0x00170011 for 24 lines.
- R4: Internal register 2 always reads 0, and writes to it are discarded.
- R5: Line n owns internal register 0x10+2n (low word) and 0x11+2n (high word). Both words read back exactly as written. In the low word, bits 7:0 are the vector, 10:8 the delivery mode, 11 the destination mode, 15 the level flag and 16 the mask. In the high word, bits 31:24 are the destination.
- R6: After reset every low word reads 0x00010000 (only the mask set), every high word reads 0, and `req_valid` is 0.
- R7: A rising edge on an unmasked line produces exactly one request whose vector is bits 7:0 of that line's low word. `req_valid` rises two clock edges after the input edge is sampled. A line that stays high produces no further requests.
- R8: A rising edge on a line whose mask bit (bit 16) is set produces no request.
- R9: Requests that are pending together are delivered in ascending line order, one per accepted transfer.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_vector` is unchanged.
- R11: Window reads with selector values 3 to 0x0F, or 0x10+2N and above, return 0, and window writes with those selectors are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq_in | input | 24 | Interrupt input lines, sampled on rising edges |
| req_valid | output | 1 | Request stream valid |
| req_ready | input | 1 | Request stream ready |
| req_vector | output | 8 | Vector of the request on offer |

## Verification
The hardest situation to reach is a large set of requests that are all pending at once while the output is stalled. Only then do ordering and stall stability both show. The bench programs a distinct vector into every entry and holds `req_ready` low. It then raises all lines in the same cycle and checks that the first vector stays fixed. Next it releases ready and checks all 24 vectors in ascending order on back-to-back transfers. It repeats the burst with the odd lines masked to show that the gaps are skipped.

// File: rtl/ioroute_pkg.sv
package ioroute_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int SEL_W       = 8;
  localparam int VEC_W       = 8;
  localparam int MASK_BIT    = 16;
  localparam int ID_LSB      = 24;
  localparam logic [ADDR_W-1:0] OFF_SEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_WIN = 8'h10;
  localparam logic [SEL_W-1:0]  IDX_ID   = 8'h00;
  localparam logic [SEL_W-1:0]  IDX_VER  = 8'h01;
  localparam logic [SEL_W-1:0]  IDX_ARB  = 8'h02;
  localparam logic [SEL_W-1:0]  IDX_ENT  = 8'h10;
  localparam logic [DATA_W-1:0] LO_RESET = 32'h0001_0000;

  function automatic logic [DATA_W-1:0] version_word(input int lines);
    version_word = 32'h11 | (DATA_W'(lines - 1) << 16);
  endfunction
endpackage

// File: rtl/ioroute_regs.sv
module ioroute_regs
  import ioroute_pkg::*;
#(
  parameter int N = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [SEL_W-1:0]       sel_o,
  output logic [N-1:0]           line_mask,
  output logic [N-1:0][VEC_W-1:0] line_vec
);
  localparam int LINE_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [SEL_W-1:0] ENT_END = SEL_W'(int'(IDX_ENT) + 2 * N);

  logic [SEL_W-1:0]          sel_q;
  logic [VEC_W-1:0]          id_q;
  logic [N-1:0][DATA_W-1:0]  lo_q;
  logic [N-1:0][DATA_W-1:0]  hi_q;
  logic                      win_wr;
  logic                      in_ent;
  logic [LINE_W-1:0]         ent_line;

  assign win_wr   = bus_wr && (bus_addr == OFF_WIN);
  assign in_ent   = (sel_q >= IDX_ENT) && (sel_q < ENT_END);
  assign ent_line = LINE_W'((sel_q - IDX_ENT) >> 1);
  assign sel_o    = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (bus_wr && (bus_addr == OFF_SEL)) sel_q <= bus_wdata[SEL_W-1:0];
      if (win_wr && (sel_q == IDX_ID))     id_q  <= bus_wdata[DATA_W-1:ID_LSB];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [SEL_W-1:0] LO_IDX = SEL_W'(int'(IDX_ENT) + 2 * g);
    localparam logic [SEL_W-1:0] HI_IDX = SEL_W'(int'(IDX_ENT) + 2 * g + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g] <= LO_RESET;
        hi_q[g] <= '0;
      end else if (win_wr) begin
        if (sel_q == LO_IDX) lo_q[g] <= bus_wdata;
        if (sel_q == HI_IDX) hi_q[g] <= bus_wdata;
      end
    end
    assign line_mask[g] = lo_q[g][MASK_BIT];
    assign line_vec[g]  = lo_q[g][VEC_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && (bus_addr == OFF_WIN)) begin
      if (sel_q == IDX_ID)       bus_rdata = {id_q, 24'h0};
      else if (sel_q == IDX_VER) bus_rdata = version_word(N);
      else if (in_ent)           bus_rdata = sel_q[0] ? hi_q[ent_line] : lo_q[ent_line];
    end
  end
endmodule

// File: rtl/ioroute_pend.sv
module ioroute_pend #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] line_mask,
  input  logic [N-1:0] grant,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] irq_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] accept;

  assign accept = irq_in & ~irq_q & ~line_mask;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= (pend_q & ~grant) | accept;
    end
  end
endmodule

// File: rtl/ioroute_out.sv
module ioroute_out
  import ioroute_pkg::*;
#(
  parameter int N = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            pend,
  input  logic [N-1:0][VEC_W-1:0] line_vec,
  input  logic                    req_ready,
  output logic                    req_valid,
  output logic [VEC_W-1:0]        req_vector,
  output logic [N-1:0]            grant
);
  logic             load;
  logic [N-1:0]     lowest;
  logic [VEC_W-1:0] pick_vec;

  assign load   = !req_valid || req_ready;
  assign lowest = pend & (~pend + N'(1));
  assign grant  = load ? lowest : '0;

  always_comb begin
    pick_vec = '0;
    for (int i = 0; i < N; i++) begin
      if (lowest[i]) pick_vec = pick_vec | line_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_vector <= '0;
    end else if (load) begin
      req_valid  <= |pend;
      req_vector <= pick_vec;
    end
  end
endmodule

// File: rtl/ioroute_top.sv
module ioroute_top
  import ioroute_pkg::*;
#(
  parameter int N = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N-1:0]      irq_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [VEC_W-1:0]  req_vector
);
  logic [SEL_W-1:0]           sel;
  logic [N-1:0]               line_mask;
  logic [N-1:0][VEC_W-1:0]    line_vec;
  logic [N-1:0]               pend;
  logic [N-1:0]               grant;

  ioroute_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_o(sel), .line_mask(line_mask), .line_vec(line_vec)
  );

  ioroute_pend #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_mask(line_mask),
    .grant(grant), .pend_o(pend)
  );

  ioroute_out #(.N(N)) u_out (
    .clk(clk), .rst_n(rst_n), .pend(pend), .line_vec(line_vec),
    .req_ready(req_ready), .req_valid(req_valid), .req_vector(req_vector),
    .grant(grant)
  );
endmodule

// File: rtl/ioroute_chk.sv
module ioroute_chk
  import ioroute_pkg::*;
#(
  parameter int N = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [SEL_W-1:0]  sel,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VEC_W-1:0]  req_vector
);
  localparam int ENT_END = int'(IDX_ENT) + 2 * N;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_vector)); // R10

  AST_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr != OFF_WIN) |-> bus_rdata == '0); // R1

  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == OFF_WIN) && (sel == IDX_VER) |-> bus_rdata == version_word(N)); // R3

  AST_ARB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == OFF_WIN) && (sel == IDX_ARB) |-> bus_rdata == '0); // R4

  AST_UNDEF_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == OFF_WIN) && ((sel > IDX_ARB && sel < IDX_ENT) || int'(sel) >= ENT_END)
    |-> bus_rdata == '0); // R11
endmodule

bind ioroute_top ioroute_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .sel(sel), .req_valid(req_valid),
  .req_ready(req_ready), .req_vector(req_vector)
);

// File: tb/sim_ioroute_top.sv
`timescale 1ns/1ps
module sim_ioroute_top;
  localparam int N = 24;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        req_valid, req_ready = 1'b1;
  logic [7:0]  req_vector;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ioroute_top #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rdsel(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, {24'h0, s});
    rd(8'h10, d);
  endtask

  task automatic wrsel(input logic [7:0] s, input logic [31:0] d);
    wr(8'h00, {24'h0, s});
    wr(8'h10, d);
  endtask

  // Holds one line high for several cycles and counts the transfers seen.
  task automatic pulse_count(input int n, output int cnt, output logic [7:0] vec);
    cnt = 0; vec = '0;
    @(negedge clk);
    irq_in[n] = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      #1;
      if (req_valid) begin cnt++; vec = req_vector; end
    end
    irq_in[n] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt;
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6 reset state
    #1 check("R6 valid", {31'h0, req_valid}, 32'h0);
    for (int n = 0; n < N; n++) begin
      rdsel(8'(16 + 2*n), d); check("R6 lo", d, 32'h0001_0000);
      rdsel(8'(17 + 2*n), d); check("R6 hi", d, 32'h0);
    end

    // R2 identification
    rdsel(8'h00, d); check("R2 reset", d, 32'h0);
    wr(8'h10, 32'hA512_3456);
    rd(8'h10, d); check("R2 write", d, 32'hA500_0000);

    // R3 version, read-only
    rdsel(8'h01, d); check("R3 read", d, 32'h0017_0011);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R3 ro", d, 32'h0017_0011);

    // R4 arbitration
    rdsel(8'h02, d); check("R4 read", d, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R4 ro", d, 32'h0);

    // R11 undefined selectors
    for (int s = 3; s < 256; s++) begin
      if (s >= 16 && s < 16 + 2*N) continue;
      wrsel(8'(s), 32'hFFFF_FFFF);
      rd(8'h10, d); check("R11 undef", d, 32'h0);
    end
    rdsel(8'h10, d); check("R11 entry intact", d, 32'h0001_0000);
    rdsel(8'h00, d); check("R11 id intact", d, 32'hA500_0000);

    // R1 offsets: only 0x10 reads non-zero; other offsets discard writes
    wr(8'h00, 32'h0000_0000);
    for (int a = 0; a < 256; a++) begin
      if (a == 16) continue;
      rd(8'(a), d); check("R1 offset read", d, 32'h0);
    end
    wr(8'h04, 32'h0000_0011);
    wr(8'h14, 32'h0000_0000);
    wr(8'h20, 32'h0000_0001);
    rd(8'h10, d); check("R1 stray write", d, 32'hA500_0000);

    // R5 readback of every word
    for (int n = 0; n < N; n++) begin
      wrsel(8'(16 + 2*n), {8'(n), 8'hC3, 8'(3*n), 8'h5A});
      wrsel(8'(17 + 2*n), {8'(255 - n), 24'h00A5A5});
    end
    for (int n = 0; n < N; n++) begin
      rdsel(8'(16 + 2*n), d); check("R5 lo", d, {8'(n), 8'hC3, 8'(3*n), 8'h5A});
      rdsel(8'(17 + 2*n), d); check("R5 hi", d, {8'(255 - n), 24'h00A5A5});
    end

    // R7 single-line requests, one per rising edge
    for (int n = 0; n < N; n++) wrsel(8'(16 + 2*n), 32'(8'h20 + n));
    for (int n = 0; n < N; n++) begin
      pulse_count(n, cnt, v);
      check("R7 count", 32'(cnt), 32'd1);
      check("R7 vector", {24'h0, v}, 32'(8'h20 + n));
    end

    // R8 masked line
    wrsel(8'(16 + 10), 32'h0001_0025);
    pulse_count(5, cnt, v);
    check("R8 masked", 32'(cnt), 32'd0);

    // R9 / R10 burst under stall
    for (int n = 0; n < N; n++) wrsel(8'(16 + 2*n), 32'(8'h40 + n));
    @(negedge clk);
    req_ready = 1'b0;
    irq_in = '1;
    repeat (4) @(negedge clk);
    #1 check("R10 valid", {31'h0, req_valid}, 32'h1);
    check("R10 vector", {24'h0, req_vector}, 32'h40);
    repeat (3) @(negedge clk);
    #1 check("R10 stable", {23'h0, req_valid, req_vector}, 32'h140);
    @(negedge clk);
    irq_in = '0;
    req_ready = 1'b1;
    for (int k = 0; k < N; k++) begin
      #1 check("R9 order", {23'h0, req_valid, req_vector}, 32'(9'h100 + 8'h40 + k));
      @(negedge clk);
    end
    #1 check("R9 drained", {31'h0, req_valid}, 32'h0);

    // R8 / R9 odd lines masked
    for (int n = 1; n < N; n += 2) wrsel(8'(16 + 2*n), 32'h0001_0000 | 32'(8'h40 + n));
    @(negedge clk);
    irq_in = '1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    for (int k = 0; k < N/2; k++) begin
      #1 check("R9 masked order", {23'h0, req_valid, req_vector}, 32'(9'h100 + 8'h40 + 2*k));
      @(negedge clk);
    end
    #1 check("R8 masked skipped", {31'h0, req_valid}, 32'h0);
    irq_in = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule